// File: doc/BRIEF.md
# Process-Tagged Translation Lookaside Buffer

This block keeps a small, fully associative set of recently used virtual-to-physical page translations. Each entry carries the process identifier of its owner, so translations for several processes can live side by side and need not be discarded when the running process changes. A lookup presents a virtual address, a read/write flag and the current process identifier. All entries are compared in the same cycle, and the block answers combinationally with a hit and a physical address, a miss, or a permission fault.

An entry covers a 4 KiB page, a 2 MiB superpage or a 1 GiB superpage. For a superpage, only the virtual page bits above the superpage boundary take part in the compare. The virtual address bits below that boundary pass straight into the physical address. Misses go to an external page table walker or trap handler, which later installs the translation through the refill port. A purge port removes translations for one process and page when their rights change, and a flush input empties the whole buffer.

Top module: `tagged_tlb`

## Requirements
- R1: After reset every entry is invalid and any lookup misses. While `lk_valid` is low, `lk_hit`, `lk_miss` and `lk_fault` are all low.
- R2: An entry matches a lookup when it is valid, its process identifier equals `cur_pid`, and its stored page number equals the lookup page number (`lk_va` bits above bit 11) on every bit the entry's size compares. If several entries match, the one with the lowest index supplies the result.
- R3: Size code 0 is 4 KiB and compares all page bits. Code 1 is 2 MiB and ignores the low 9 page bits. Codes 2 and 3 are 1 GiB and ignore the low 18 page bits. On a hit, `lk_pa` is the entry frame with its ignored low bits replaced by the same lookup page bits, followed by `lk_va[11:0]`.
- R4: When `lk_valid` is high, exactly one of hit, miss or fault is asserted. A lookup with no matching entry asserts `lk_miss`. `lk_pa` is zero whenever `lk_hit` is low.
- R5: A write lookup (`lk_write`=1) that matches an entry whose write right is clear (`fill_rw`=0 at refill) asserts `lk_fault` instead of `lk_hit`. A read lookup of the same entry hits.
- R6: A refill installs its entry into the lowest-index invalid entry. The entry is visible to lookups from the next cycle.
- R7: When no entry is invalid, a refill replaces the entry at a round-robin pointer. The pointer starts at 0 after reset and advances by one, wrapping after the last entry, only on such refills.
- R8: A purge invalidates every valid entry whose process identifier equals `purge_pid` and whose compared page bits equal those of `purge_vpn`. All other entries are unchanged.
- R9: `flush_all` invalidates every entry in one cycle. It overrides a purge or refill issued in the same cycle, and it leaves the round-robin pointer unchanged.
- R10: If a purge and a refill arrive in the same cycle, both take effect, with the refill written last. The refill victim is chosen from the valid bits as they stood before that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cur_pid | input | PID_W | Process identifier of the running context |
| lk_valid | input | 1 | Lookup request |
| lk_va | input | VA_W | Lookup virtual address |
| lk_write | input | 1 | Lookup is a write access |
| lk_hit | output | 1 | Translation found and permitted |
| lk_miss | output | 1 | No matching translation |
| lk_fault | output | 1 | Write to a read-only translation |
| lk_pa | output | PA_W | Physical address on a hit, else zero |
| fill_en | input | 1 | Refill request |
| fill_vpn | input | VA_W-12 | Refill virtual page number |
| fill_pid | input | PID_W | Refill process identifier |
| fill_pfn | input | PA_W-12 | Refill frame number |
| fill_size | input | 2 | Refill size code (0 4 KiB, 1 2 MiB, 2/3 1 GiB) |
| fill_rw | input | 1 | Refill write right |
| purge_en | input | 1 | Purge request |
| purge_pid | input | PID_W | Purge process identifier |
| purge_vpn | input | VA_W-12 | Purge virtual page number |
| flush_all | input | 1 | Invalidate all entries |

## Verification
The lookup path is tried with addresses that differ from a stored page only below a superpage boundary, which separates correct masking from full-width compares. It is also tried with the same page under a different process identifier, which shows whether the tag takes part in the match. Reads and writes to read-only and writable entries separate faults from hits. A run of refills past capacity, then lookups of the oldest pages, shows the free-first and round-robin victim order. Purges aimed inside a superpage, purges combined with refills, and flushes combined with refills test the update ordering. A long random phase then draws from a small set of processes and pages, so duplicate and overlapping entries exercise the lowest-index priority.

// File: rtl/tagged_tlb.sv
module tagged_tlb #(
  parameter int ENTRIES = 8,
  parameter int PID_W   = 8,
  parameter int VA_W    = 40,
  parameter int PA_W    = 40
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [PID_W-1:0]     cur_pid,
  input  logic                 lk_valid,
  input  logic [VA_W-1:0]      lk_va,
  input  logic                 lk_write,
  output logic                 lk_hit,
  output logic                 lk_miss,
  output logic                 lk_fault,
  output logic [PA_W-1:0]      lk_pa,
  input  logic                 fill_en,
  input  logic [VA_W-13:0]     fill_vpn,
  input  logic [PID_W-1:0]     fill_pid,
  input  logic [PA_W-13:0]     fill_pfn,
  input  logic [1:0]           fill_size,
  input  logic                 fill_rw,
  input  logic                 purge_en,
  input  logic [PID_W-1:0]     purge_pid,
  input  logic [VA_W-13:0]     purge_vpn,
  input  logic                 flush_all
);
  localparam int OFF_W = 12;
  localparam int LVL_W = 9;
  localparam int VPN_W = VA_W - OFF_W;
  localparam int PFN_W = PA_W - OFF_W;
  localparam int IDX_W = $clog2(ENTRIES);

  function automatic logic [VPN_W-1:0] vmask(input logic [1:0] sz);
    case (sz)
      2'd0:    vmask = '1;
      2'd1:    vmask = {{(VPN_W-LVL_W){1'b1}}, {LVL_W{1'b0}}};
      default: vmask = {{(VPN_W-2*LVL_W){1'b1}}, {(2*LVL_W){1'b0}}};
    endcase
  endfunction

  function automatic logic [PFN_W-1:0] pmask(input logic [1:0] sz);
    case (sz)
      2'd0:    pmask = '1;
      2'd1:    pmask = {{(PFN_W-LVL_W){1'b1}}, {LVL_W{1'b0}}};
      default: pmask = {{(PFN_W-2*LVL_W){1'b1}}, {(2*LVL_W){1'b0}}};
    endcase
  endfunction

  logic [ENTRIES-1:0] v_q;
  logic [PID_W-1:0]   pid_q [ENTRIES];
  logic [VPN_W-1:0]   vpn_q [ENTRIES];
  logic [PFN_W-1:0]   pfn_q [ENTRIES];
  logic [1:0]         sz_q  [ENTRIES];
  logic [ENTRIES-1:0] rw_q;
  logic [IDX_W-1:0]   rr_q;

  logic [VPN_W-1:0]   lk_vpn;
  logic [ENTRIES-1:0] match_vec, purge_vec;
  logic [IDX_W-1:0]   sel_idx, free_idx, victim;
  logic               any_match, any_free, ro_viol, do_fill;
  logic [PFN_W-1:0]   frame;
  logic [ENTRIES-1:0] v_next;

  assign lk_vpn = lk_va[VA_W-1:OFF_W];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match_vec[g] = v_q[g] && (pid_q[g] == cur_pid) &&
                          (((lk_vpn ^ vpn_q[g]) & vmask(sz_q[g])) == '0);
    assign purge_vec[g] = v_q[g] && (pid_q[g] == purge_pid) &&
                          (((purge_vpn ^ vpn_q[g]) & vmask(sz_q[g])) == '0);
  end

  always_comb begin
    sel_idx  = '0;
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match_vec[i]) sel_idx = IDX_W'(i);
      if (!v_q[i])      free_idx = IDX_W'(i);
    end
  end

  assign any_match = |match_vec;
  assign any_free  = ~&v_q;
  assign victim    = any_free ? free_idx : rr_q;
  assign do_fill   = fill_en && !flush_all;

  assign ro_viol  = lk_write && !rw_q[sel_idx];
  assign lk_hit   = lk_valid && any_match && !ro_viol;
  assign lk_fault = lk_valid && any_match && ro_viol;
  assign lk_miss  = lk_valid && !any_match;

  assign frame = (pfn_q[sel_idx] & pmask(sz_q[sel_idx])) |
                 ({{(PFN_W-2*LVL_W){1'b0}}, lk_vpn[2*LVL_W-1:0]} & ~pmask(sz_q[sel_idx]));
  assign lk_pa = lk_hit ? {frame, lk_va[OFF_W-1:0]} : '0;

  always_comb begin
    v_next = v_q & ~(purge_en ? purge_vec : '0);
    if (do_fill) v_next[victim] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q  <= '0;
      rr_q <= '0;
    end else if (flush_all) begin
      v_q <= '0;
    end else begin
      v_q <= v_next;
      if (fill_en && !any_free)
        rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (do_fill) begin
      pid_q[victim] <= fill_pid;
      vpn_q[victim] <= fill_vpn;
      pfn_q[victim] <= fill_pfn;
      sz_q[victim]  <= fill_size;
      rw_q[victim]  <= fill_rw;
    end
  end

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> !(lk_hit || lk_miss || lk_fault));

  p_one_outcome_r4: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |-> $onehot({lk_hit, lk_miss, lk_fault}));

  p_pa_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> lk_pa == '0);

  p_fault_on_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lk_fault |-> lk_write);

  p_fill_lands_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en && !flush_all |=> v_q != '0);

  p_rr_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en && !flush_all && (&v_q) |=>
      rr_q == (($past(rr_q) == IDX_W'(ENTRIES - 1)) ? '0 : $past(rr_q) + 1'b1));

  p_rr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(fill_en && !flush_all && (&v_q)) |=> $stable(rr_q));

  p_flush_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |=> v_q == '0);
endmodule

// File: tb/test_tagged_tlb.sv
module test_tagged_tlb;
  localparam int E = 8, PW = 8, VW = 40, AW = 40;
  localparam int VPNW = VW - 12, PFNW = AW - 12;

  logic clk = 0, rst_n = 0;
  logic [PW-1:0] cur_pid = 0, fill_pid = 0, purge_pid = 0;
  logic lk_valid = 0, lk_write = 0, fill_en = 0, fill_rw = 0, purge_en = 0, flush_all = 0;
  logic [VW-1:0] lk_va = 0;
  logic [VPNW-1:0] fill_vpn = 0, purge_vpn = 0;
  logic [PFNW-1:0] fill_pfn = 0;
  logic [1:0] fill_size = 0;
  logic lk_hit, lk_miss, lk_fault;
  logic [AW-1:0] lk_pa;

  int compared = 0, mismatched = 0;

  bit         m_v   [E];
  int         m_pid [E];
  logic [63:0] m_vpn [E];
  logic [63:0] m_pfn [E];
  int         m_sz  [E];
  bit         m_rw  [E];
  int         m_rr;

  always #4 clk = ~clk;

  tagged_tlb #(.ENTRIES(E), .PID_W(PW), .VA_W(VW), .PA_W(AW)) i_tagged_tlb (
    .clk(clk), .rst_n(rst_n), .cur_pid(cur_pid), .lk_valid(lk_valid), .lk_va(lk_va),
    .lk_write(lk_write), .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_fault(lk_fault),
    .lk_pa(lk_pa), .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_pid(fill_pid),
    .fill_pfn(fill_pfn), .fill_size(fill_size), .fill_rw(fill_rw), .purge_en(purge_en),
    .purge_pid(purge_pid), .purge_vpn(purge_vpn), .flush_all(flush_all));

  function automatic bit covers(int sz, logic [63:0] a, logic [63:0] b);
    int sh = (sz == 0) ? 0 : (sz == 1) ? 9 : 18;
    return (a >> sh) == (b >> sh);
  endfunction

  task automatic report();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  task automatic tick(input string tag);
    logic [63:0] vpn, pa;
    int sel, victim, sh;
    bit eh, em, ef, full;
    #1;
    vpn = 64'(lk_va) >> 12;
    sel = -1;
    for (int i = 0; i < E; i++)
      if (sel < 0 && rst_n && m_v[i] && m_pid[i] == int'(cur_pid) && covers(m_sz[i], m_vpn[i], vpn))
        sel = i;
    eh = lk_valid && sel >= 0 && !(lk_write && !m_rw[sel]);
    ef = lk_valid && sel >= 0 && lk_write && !m_rw[sel];
    em = lk_valid && sel < 0;
    pa = 0;
    if (eh) begin
      sh = (m_sz[sel] == 0) ? 0 : (m_sz[sel] == 1) ? 9 : 18;
      pa = (((m_pfn[sel] >> sh) << sh) | (vpn & ((64'd1 << sh) - 1))) << 12;
      pa = pa | (64'(lk_va) & 64'hfff);
    end
    compared++;
    if (lk_hit !== eh || lk_miss !== em || lk_fault !== ef || lk_pa !== pa[AW-1:0]) begin
      mismatched++;
      $display("FAIL %s: hit/miss/fault/pa got %b%b%b %h exp %b%b%b %h",
               tag, lk_hit, lk_miss, lk_fault, lk_pa, eh, em, ef, pa[AW-1:0]);
    end
    @(posedge clk);
    if (!rst_n) begin
      for (int i = 0; i < E; i++) m_v[i] = 0;
      m_rr = 0;
    end else if (flush_all) begin
      for (int i = 0; i < E; i++) m_v[i] = 0;
    end else begin
      victim = -1;
      for (int i = 0; i < E; i++) if (victim < 0 && !m_v[i]) victim = i;
      full = (victim < 0);
      if (full) victim = m_rr;
      if (purge_en)
        for (int i = 0; i < E; i++)
          if (m_v[i] && m_pid[i] == int'(purge_pid) && covers(m_sz[i], m_vpn[i], 64'(purge_vpn)))
            m_v[i] = 0;
      if (fill_en) begin
        m_v[victim] = 1; m_pid[victim] = int'(fill_pid); m_vpn[victim] = 64'(fill_vpn);
        m_pfn[victim] = 64'(fill_pfn); m_sz[victim] = int'(fill_size); m_rw[victim] = fill_rw;
        if (full) m_rr = (m_rr + 1) % E;
      end
    end
    @(negedge clk);
  endtask

  task automatic idle();
    fill_en = 0; purge_en = 0; flush_all = 0; lk_valid = 0; lk_write = 0;
  endtask

  task automatic look(input int pid, input logic [63:0] va, input bit wr, input string tag);
    idle();
    cur_pid = PW'(pid); lk_va = VW'(va); lk_valid = 1; lk_write = wr;
    tick(tag);
  endtask

  task automatic fill(input int pid, input logic [63:0] vpn, input logic [63:0] pfn,
                      input int sz, input bit rw, input string tag);
    idle();
    fill_en = 1; fill_pid = PW'(pid); fill_vpn = VPNW'(vpn); fill_pfn = PFNW'(pfn);
    fill_size = 2'(sz); fill_rw = rw;
    tick(tag);
  endtask

  initial begin
    #(8 * 200000);
    mismatched++;
    $display("FAIL watchdog: got timeout exp completion");
    report();
  end

  initial begin
    @(negedge clk);
    look(1, 64'h5000, 0, "R1 miss during reset");
    rst_n = 1;
    look(1, 64'h5000, 0, "R1 miss after reset");
    idle(); tick("R1 idle outputs low");

    fill(1, 64'h5, 64'habc, 0, 1, "R6 fill 4K");
    look(1, 64'h5123, 0, "R2 R3 hit 4K");
    look(2, 64'h5123, 0, "R2 other process misses");
    look(1, 64'h6123, 1, "R4 neighbour page misses");
    look(1, 64'h5fff, 1, "R5 write to writable hits");

    fill(1, 64'h400, 64'h1200, 1, 0, "R6 fill 2M read-only");
    look(1, 64'h437123, 0, "R3 2M pass-through");
    look(1, 64'h437123, 1, "R5 write read-only faults");
    fill(3, 64'h40000, 64'h80000, 2, 1, "R6 fill 1G");
    look(3, 64'h4abcd456, 0, "R3 1G pass-through");
    fill(3, 64'h80000, 64'h1c0000, 3, 1, "R6 fill size code 3");
    look(3, 64'h8012_3456, 0, "R3 size code 3 acts as 1G");

    idle(); purge_en = 1; purge_pid = 1; purge_vpn = 28'h410; tick("R8 purge inside 2M");
    look(1, 64'h437123, 0, "R8 purged superpage misses");
    look(1, 64'h5123, 0, "R8 other entry kept");
    idle(); purge_en = 1; purge_pid = 2; purge_vpn = 28'h5; tick("R8 wrong pid purge");
    look(1, 64'h5123, 0, "R8 wrong pid purge has no effect");

    idle(); purge_en = 1; purge_pid = 1; purge_vpn = 28'h5;
    fill_en = 1; fill_pid = 1; fill_vpn = 28'h5; fill_pfn = 28'h777; fill_size = 0; fill_rw = 1;
    tick("R10 purge and fill together");
    look(1, 64'h5001, 0, "R10 refill survives purge");

    idle(); flush_all = 1; fill_en = 1; fill_pid = 1; fill_vpn = 28'h9; tick("R9 flush with fill");
    look(1, 64'h9000, 0, "R9 flush beats fill");
    look(3, 64'h4abcd456, 0, "R9 flush clears all");

    for (int k = 0; k < 11; k++) fill(4, 64'h100 + k, 64'h2000 + k, 0, 1, "R7 fill past capacity");
    for (int k = 0; k < 11; k++) look(4, (64'h100 + k) << 12, 0, "R7 round-robin order");

    for (int n = 0; n < 3000; n++) begin
      idle();
      cur_pid = PW'($urandom_range(0, 3));
      lk_valid = ($urandom_range(0, 9) != 0);
      lk_write = $urandom_range(0, 1);
      lk_va = VW'({$urandom_range(0, 3), 18'($urandom_range(0, 3)), 12'($urandom)});
      lk_va[29:18] = 12'($urandom_range(0, 3) == 0 ? $urandom_range(0, 1) : 0);
      fill_en = ($urandom_range(0, 3) == 0);
      fill_pid = PW'($urandom_range(0, 3));
      fill_vpn = VPNW'({$urandom_range(0, 1), 18'($urandom_range(0, 3))});
      fill_vpn[8:0] = 9'($urandom_range(0, 3));
      fill_pfn = PFNW'($urandom);
      fill_size = 2'($urandom_range(0, 3));
      fill_rw = $urandom_range(0, 1);
      purge_en = ($urandom_range(0, 7) == 0);
      purge_pid = PW'($urandom_range(0, 3));
      purge_vpn = VPNW'($urandom_range(0, 3));
      flush_all = ($urandom_range(0, 99) == 0);
      tick("R2 R4 R6 R8 random");
    end

    report();
  end
endmodule